// File: doc/BRIEF.md
# Set/Clear Peripheral Reset Control Register

This block is one 32-bit control word that holds a reset-control bit for each on-chip peripheral. Each implemented bit leaves the block as a registered output that goes straight to the reset input of its peripheral. Software can change any group of bits in a single write without a read-modify-write sequence, so two agents that touch different peripherals can never overwrite each other's bits.

The word has three word-aligned aliases in a small local address space. The view alias at offset 0x0 returns the current value, and writes to it are ignored. A write to the clear alias at offset 0x4 clears every bit whose write-data bit is 1. A write to the set alias at offset 0x8 sets every bit whose write-data bit is 1. In both cases the bits written as 0 keep their value. Only the positions in the implemented mask can be written. The other positions are reserved: they read as 0 and never change.

After system reset the word is 0, except bit 0, the external reset bit, which comes up as 1. The bus is plain and synchronous, with an address, a write strobe, write data and read data. It has no handshake and no wait states, so every write takes effect at the clock edge where the strobe is seen.

Top module: `prc_reset_ctl`

## Requirements
- R1: While reset is asserted and just after it is released, the register value and `rst_ctl_o` are 0x0000_0001, with only bit 0 set.
- R2: A write to offset 0x8 sets every implemented bit whose write-data bit is 1. The new value appears on `rst_ctl_o` and `rdata_o` one clock after the write edge.
- R3: A write to offset 0x4 clears every implemented bit whose write-data bit is 1. The new value appears one clock after the write edge.
- R4: During a write to offset 0x4 or 0x8, every bit whose write-data bit is 0 keeps its previous value.
- R5: Reserved positions 31:18, 16, 4:3 and 1 read as 0 and stay 0 on `rst_ctl_o`, whatever is written through any alias. The implemented mask is 0x0002_FFE5.
- R6: A write to offset 0x0, or to any offset other than 0x4 and 0x8 (for example 0xC), leaves the register unchanged.
- R7: `rdata_o` combinationally shows the current register value when `addr_i` is 0x0, 0x4 or 0x8, and shows 0 for any other offset.
- R8: `rst_ctl_o` is the register itself, with no added stage between a bit and its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| addr_i | input | 4 | Byte offset within the block |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data, used as a bit mask by the clear and set aliases |
| rdata_o | output | 32 | Read data for the addressed alias |
| rst_ctl_o | output | 32 | Per-peripheral reset controls, with reserved positions held at 0 |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 4-bit offset, the implemented mask 0x0002_FFE5 and the reset value 0x0000_0001. The mask mixes isolated bits (0, 2, 17), a contiguous run (15:5) and reserved holes both between and around them. All-ones writes through every alias therefore show at once whether a reserved position can leak. Because the reset value has one bit set, the bench can check that a clear really reaches a bit that was not set by software, and that unrelated set writes leave that bit alone.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFS_W-1:0]  ofs_t;

  localparam ofs_t OFS_VIEW  = 4'h0;
  localparam ofs_t OFS_CLEAR = 4'h4;
  localparam ofs_t OFS_SET   = 4'h8;

  localparam word_t IMPL_MASK_DEF = 32'h0002_FFE5;
  localparam word_t RESET_VAL_DEF = 32'h0000_0001;

  typedef struct packed {
    logic view;
    logic clr;
    logic set;
  } hit_t;
endpackage

// File: rtl/prc_decode.sv
module prc_decode
  import prc_pkg::*;
#(
  parameter int unsigned AW = OFS_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  output hit_t          rd_hit_o,
  output logic          wr_set_o,
  output logic          wr_clr_o
);
  localparam logic [AW-1:0] A_VIEW = AW'(OFS_VIEW);
  localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLEAR);
  localparam logic [AW-1:0] A_SET  = AW'(OFS_SET);

  always_comb begin
    rd_hit_o.view = (addr_i == A_VIEW);
    rd_hit_o.clr  = (addr_i == A_CLR);
    rd_hit_o.set  = (addr_i == A_SET);
    wr_set_o      = wr_en_i && rd_hit_o.set;
    wr_clr_o      = wr_en_i && rd_hit_o.clr;
  end

  always_comb begin
    assert_one_strobe_R6: assert (!(wr_set_o && wr_clr_o));
  end
endmodule

// File: rtl/prc_bit.sv
module prc_bit #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_bit_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= RST_VAL;
    end else if (mask_bit_i) begin
      if (set_i)      q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/prc_readmux.sv
module prc_readmux
  import prc_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  hit_t          hit_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (hit_i.view || hit_i.clr || hit_i.set) rdata_o = word_i;
  end
endmodule

// File: rtl/prc_reset_ctl.sv
module prc_reset_ctl
  import prc_pkg::*;
#(
  parameter int unsigned     DW        = WORD_W,
  parameter int unsigned     AW        = OFS_W,
  parameter logic [DW-1:0]   IMPL_MASK = DW'(IMPL_MASK_DEF),
  parameter logic [DW-1:0]   RESET_VAL = DW'(RESET_VAL_DEF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] rst_ctl_o
);
  localparam logic [DW-1:0] RSVD_MASK = ~IMPL_MASK;

  hit_t          rd_hit;
  logic          wr_set, wr_clr;
  logic [DW-1:0] word_q;

  prc_decode #(.AW(AW)) u_dec (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_hit_o (rd_hit),
    .wr_set_o (wr_set),
    .wr_clr_o (wr_clr)
  );

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      prc_bit #(.RST_VAL(RESET_VAL[b])) u_cell (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (wr_set),
        .clr_i      (wr_clr),
        .mask_bit_i (wdata_i[b]),
        .q_o        (word_q[b])
      );
    end else begin : g_rsvd
      assign word_q[b] = 1'b0;
    end
  end

  prc_readmux #(.DW(DW)) u_rd (
    .hit_i   (rd_hit),
    .word_i  (word_q),
    .rdata_o (rdata_o)
  );

  assign rst_ctl_o = word_q;

  assert_reset_value_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (rst_ctl_o == (RESET_VAL & IMPL_MASK)));

  assert_set_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(OFS_SET))
      |=> ((rst_ctl_o & $past(wdata_i) & IMPL_MASK) == ($past(wdata_i) & IMPL_MASK)));

  assert_clear_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(OFS_CLEAR))
      |=> ((rst_ctl_o & $past(wdata_i)) == '0));

  assert_untouched_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == AW'(OFS_SET) || addr_i == AW'(OFS_CLEAR)))
      |=> ((rst_ctl_o & ~$past(wdata_i)) == ($past(rst_ctl_o) & ~$past(wdata_i))));

  assert_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rst_ctl_o & RSVD_MASK) == '0) && ((rdata_o & RSVD_MASK) == '0));

  assert_no_alias_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == AW'(OFS_SET) || addr_i == AW'(OFS_CLEAR)))
      |=> $stable(rst_ctl_o));

  assert_read_view_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFS_VIEW) || addr_i == AW'(OFS_CLEAR) || addr_i == AW'(OFS_SET))
      |-> (rdata_o == rst_ctl_o));
endmodule

// File: tb/prc_reset_ctl_tb.sv
module prc_reset_ctl_tb_top;
  localparam logic [31:0] MASK = 32'h0002_FFE5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rctl;
  logic [31:0] model = 32'h1;
  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prc_reset_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_ctl_o(rctl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0; addr = 4'h0;
    if (a == 4'h8) model = (model | d) & MASK;
    else if (a == 4'h4) model = model & ~d;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 during reset", rctl, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", rctl, 32'h1);
    chk("R7 view read", rdata, 32'h1);
  endtask

  task automatic t_set_single;
    wr_word(4'h8, 32'h0000_0020);
    chk("R2 set bit5", rctl, model);
    chk("R8 output is word", rctl, 32'h0000_0021);
  endtask

  task automatic t_set_multi;
    wr_word(4'h8, 32'h0002_8004);
    chk("R2 set multiple", rctl, 32'h0002_8025);
    chk("R4 others kept on set", rctl & ~32'h0002_8004, 32'h0000_0021);
  endtask

  task automatic t_clear;
    wr_word(4'h4, 32'h0000_0001);
    chk("R3 clear bit0", rctl, 32'h0002_8024);
    wr_word(4'h4, 32'h0002_0020);
    chk("R3 clear multiple", rctl, 32'h0000_8004);
    chk("R4 others kept on clear", rctl, model);
  endtask

  task automatic t_reserved;
    wr_word(4'h8, 32'hFFFF_FFFF);
    chk("R5 all-ones set masked", rctl, MASK);
    chk("R5 reserved read zero", rdata & ~MASK, 32'h0);
    wr_word(4'h4, 32'hFFFF_FFFF);
    chk("R3 clear all", rctl, 32'h0);
    wr_word(4'h8, 32'hFFFD_001A);
    chk("R5 reserved-only set", rctl, 32'h0);
  endtask

  task automatic t_ignored;
    wr_word(4'h8, 32'h0000_0401);
    wr_word(4'h0, 32'hFFFF_FFFF);
    chk("R6 view alias write", rctl, 32'h0000_0401);
    wr_word(4'hC, 32'hFFFF_FFFF);
    chk("R6 offset C write", rctl, 32'h0000_0401);
  endtask

  task automatic t_reads;
    addr = 4'h4; #1;
    chk("R7 clear alias read", rdata, model);
    addr = 4'h8; #1;
    chk("R7 set alias read", rdata, model);
    addr = 4'hC; #1;
    chk("R7 other offset reads zero", rdata, 32'h0);
    addr = 4'h0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_set_single();
    t_set_multi();
    t_clear();
    t_reserved();
    t_ignored();
    t_reads();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule